// File: doc/BRIEF.md
# Pipelined SPI Register Slave for a Rotary Angle Sensor

This block is the serial front end of a magnetic angle sensor. A host acts as SPI master in mode 1 (clock idle low, data launched on the rising edge and captured on the falling edge). It exchanges 16-bit frames with the block and reaches a small bank of registers. Those registers hold the live angle word, a gain setting, a fixed configuration word, the error status, and a power-on-reset control byte.

Each frame is both a command and the carrier of the previous reply. The block answers a command one full frame later. A write takes two frames: first the address, then the data. Every frame the host sends is checked in three ways: even parity, a clock count of exactly sixteen, and an address that is legal for the requested direction. Any failure sets a sticky error flag, which then rides in every reply until a dedicated clear command is sent.

The SPI pins are brought into the system clock domain through two-flop synchronisers, and all edge detection happens in that domain. The system clock must therefore run several times faster than SCK.

Top module: `sens_spi_slave`

## Requirements
- R1: A host frame whose 16 bits do not have even parity (bit 0 makes the count of ones even) sets the error flag and status bit 0, and it is not executed.
- R2: The reply to the frame sent in transfer N is shifted out, MSB first, during transfer N+1. The reply during the first transfer after reset is 0x0000.
- R3: A reply word carries 14 data bits in bits 15..2, the error flag in bit 1 and even parity in bit 0.
- R4: A command frame has bit 15 = 1 for read, bits 14..1 = address and bit 0 = parity. A write command (bit 15 = 0) is followed by a data frame whose bits 15..2 are the value. The reply to the write command is the old register content, and the reply to the data frame is the new content.
- R5: A transfer with a number of SCK falling edges other than 16 while SS is low sets the error flag and status bit 1.
- R6: A read of an undefined address, or a write to an address that is not writable, sets the error flag and status bit 2. The reply data is then 0.
- R7: The error flag stays set until a read of 0x3380. The reply to that read is 0x0000, and the read also clears the error status.
- R8: A read of 0x335A returns the error status: parity error in bit 0, clock-count error in bit 1, address error in bit 2.
- R9: Writing to 0x3C00 pulses `sw_reset` and restores the gain and reset-control registers to their reset values. When data bit 0 (frame bit 2) is 1, the error flag and status are cleared as well. The reply to the data frame is 0 data.
- R10: The 8-bit register at 0x3F22 resets to 0. `por_disable` is high exactly while it holds 0x5A.
- R11: `miso_oe` is low while SS is high and high during a transfer. MISO changes only after SCK rising edges.
- R12: A data frame that fails a check cancels the pending write and leaves every register unchanged.
- R13: The all-zero frame (address 0) is a no-operation. It returns data 0 and never starts a write.
- R14: Register map: angle 0x3FFF reads `meas_in`; gain 0x3FF8 is 6 bits, read/write, reset 0x20; configuration 0x3F20 reads 0x0200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from host |
| ss_n | input | 1 | SPI slave select, active low |
| mosi | input | 1 | Serial data from host |
| meas_in | input | 14 | Current angle word with alarm bits |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| por_disable | output | 1 | High when the reset-control register holds the disable key |
| sw_reset | output | 1 | One-cycle software reset pulse |

## Verification
The assertions assume the host never moves SCK in the same synchronised cycle as SS. They also assume each SCK level and each SS gap last several system clocks, so every edge is seen once and frame processing finishes before the next select. The bench holds every SCK phase for eight clocks and leaves twelve idle clocks after each SS release. It varies only the clock count, the parity and the frame content. Frames with too few and too many clocks are driven deliberately, and the checks then judge the error flag and status the block reports in later replies.

// File: rtl/sens_spi_pkg.sv
package sens_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 14;

  localparam logic [DATA_W-1:0] A_NOP   = 14'h0000;
  localparam logic [DATA_W-1:0] A_CLR   = 14'h3380;
  localparam logic [DATA_W-1:0] A_STAT  = 14'h335A;
  localparam logic [DATA_W-1:0] A_SWRST = 14'h3C00;
  localparam logic [DATA_W-1:0] A_CFG   = 14'h3F20;
  localparam logic [DATA_W-1:0] A_POR   = 14'h3F22;
  localparam logic [DATA_W-1:0] A_AGC   = 14'h3FF8;
  localparam logic [DATA_W-1:0] A_ANGLE = 14'h3FFF;

  localparam logic [DATA_W-1:0] CFG_WORD = 14'h0200;

  localparam int ST_PAR = 0;
  localparam int ST_CLK = 1;
  localparam int ST_ADR = 2;
  localparam int STAT_W = 3;

  function automatic logic [FRAME_W-1:0] mk_reply(input logic [DATA_W-1:0] d,
                                                  input logic ef);
    return {d, ef, ^{d, ef}};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic ssn_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel_end,
  output logic sel_active,
  output logic mosi_s
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] stage_q [STAGES];
  logic            sck_d_q;
  logic            ssn_d_q;
  logic            sck_s;
  logic            ssn_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 3'b010;
          else     stage_q[g] <= {mosi_i, ssn_i, sck_i};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 3'b010;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sck_s  = stage_q[STAGES-1][0];
  assign ssn_s  = stage_q[STAGES-1][1];
  assign mosi_s = stage_q[STAGES-1][2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d_q <= 1'b0;
      ssn_d_q <= 1'b1;
    end else begin
      sck_d_q <= sck_s;
      ssn_d_q <= ssn_s;
    end
  end

  assign sck_rise   = sck_s & ~sck_d_q;
  assign sck_fall   = ~sck_s & sck_d_q;
  assign sel_start  = ~ssn_s & ssn_d_q;
  assign sel_end    = ssn_s & ~ssn_d_q;
  assign sel_active = ~ssn_s;
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               sel_start,
  input  logic               sel_end,
  input  logic               sel_active,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output logic [FRAME_W-1:0] rx_word,
  output logic               frame_done,
  output logic               count_ok,
  output logic               miso,
  output logic               miso_oe
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] rx_sr_q;
  logic [FRAME_W-1:0] tx_sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               miso_q;
  logic               oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      cnt_q      <= '0;
      miso_q     <= 1'b0;
      oe_q       <= 1'b0;
      rx_word    <= '0;
      frame_done <= 1'b0;
      count_ok   <= 1'b0;
    end else begin
      oe_q       <= sel_active;
      frame_done <= 1'b0;
      if (sel_start) begin
        tx_sr_q <= tx_word;
        cnt_q   <= '0;
      end else if (sel_active) begin
        if (sck_fall) begin
          rx_sr_q <= {rx_sr_q[FRAME_W-2:0], mosi_s};
          if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_rise) begin
          miso_q  <= tx_sr_q[FRAME_W-1];
          tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b0};
        end
      end
      if (sel_end) begin
        frame_done <= 1'b1;
        rx_word    <= rx_sr_q;
        count_ok   <= (cnt_q == CNT_W'(FRAME_W));
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX)); // R5
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sck_rise |=> $stable(miso)); // R11
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sel_active |=> !miso_oe); // R11
endmodule

// File: rtl/sens_reg_bank.sv
module sens_reg_bank
  import sens_spi_pkg::*;
#(
  parameter int              AGC_W    = 6,
  parameter logic [AGC_W-1:0] AGC_INIT = 6'h20,
  parameter int              POR_W    = 8,
  parameter logic [POR_W-1:0] POR_KEY  = 8'h5A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               count_ok,
  input  logic [DATA_W-1:0]  meas_in,
  output logic [FRAME_W-1:0] tx_word,
  output logic               por_disable,
  output logic               sw_reset
);
  logic [AGC_W-1:0]  agc_q;
  logic [POR_W-1:0]  por_q;
  logic [STAT_W-1:0] stat_q;
  logic              err_q;
  logic              wr_pend_q;
  logic [DATA_W-1:0] wr_addr_q;
  logic [FRAME_W-1:0] tx_q;
  logic              sw_q;

  logic [DATA_W-1:0] cmd_addr;
  logic              is_read;
  logic              par_bad;
  logic              clk_bad;
  logic              rd_ok;
  logic              wr_ok;
  logic              adr_bad;
  logic              frame_bad;
  logic [DATA_W-1:0] rd_data;
  logic [STAT_W-1:0] new_stat;

  assign cmd_addr = rx_word[FRAME_W-2:1];
  assign is_read  = rx_word[FRAME_W-1];
  assign par_bad  = ^rx_word;
  assign clk_bad  = ~count_ok;

  always_comb begin
    rd_ok   = 1'b0;
    wr_ok   = 1'b0;
    rd_data = '0;
    case (cmd_addr)
      A_NOP:   begin rd_ok = 1'b1; wr_ok = 1'b1; end
      A_CLR:   rd_ok = 1'b1;
      A_STAT:  begin rd_ok = 1'b1; rd_data = DATA_W'(stat_q); end
      A_SWRST: wr_ok = 1'b1;
      A_CFG:   begin rd_ok = 1'b1; rd_data = CFG_WORD; end
      A_POR:   begin rd_ok = 1'b1; wr_ok = 1'b1; rd_data = DATA_W'(por_q); end
      A_AGC:   begin rd_ok = 1'b1; wr_ok = 1'b1; rd_data = DATA_W'(agc_q); end
      A_ANGLE: begin rd_ok = 1'b1; rd_data = meas_in; end
      default: ;
    endcase
  end

  assign adr_bad   = ~wr_pend_q & ~par_bad & ~clk_bad & ~(is_read ? rd_ok : wr_ok);
  assign frame_bad = par_bad | clk_bad | adr_bad;

  always_comb begin
    new_stat         = '0;
    new_stat[ST_PAR] = par_bad;
    new_stat[ST_CLK] = clk_bad;
    new_stat[ST_ADR] = adr_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agc_q     <= AGC_INIT;
      por_q     <= '0;
      stat_q    <= '0;
      err_q     <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_addr_q <= '0;
      tx_q      <= '0;
      sw_q      <= 1'b0;
    end else begin
      sw_q <= 1'b0;
      if (frame_done) begin
        if (frame_bad) begin
          err_q     <= 1'b1;
          stat_q    <= stat_q | new_stat;
          wr_pend_q <= 1'b0;
          tx_q      <= mk_reply('0, 1'b1);
        end else if (wr_pend_q) begin
          wr_pend_q <= 1'b0;
          case (wr_addr_q)
            A_AGC: begin
              agc_q <= rx_word[2 +: AGC_W];
              tx_q  <= mk_reply(DATA_W'(rx_word[2 +: AGC_W]), err_q);
            end
            A_POR: begin
              por_q <= rx_word[2 +: POR_W];
              tx_q  <= mk_reply(DATA_W'(rx_word[2 +: POR_W]), err_q);
            end
            A_SWRST: begin
              agc_q <= AGC_INIT;
              por_q <= '0;
              sw_q  <= 1'b1;
              if (rx_word[2]) begin
                err_q  <= 1'b0;
                stat_q <= '0;
                tx_q   <= mk_reply('0, 1'b0);
              end else begin
                tx_q   <= mk_reply('0, err_q);
              end
            end
            default: tx_q <= mk_reply('0, err_q);
          endcase
        end else if (cmd_addr == A_NOP) begin
          tx_q <= mk_reply('0, err_q);
        end else if (is_read) begin
          if (cmd_addr == A_CLR) begin
            err_q  <= 1'b0;
            stat_q <= '0;
            tx_q   <= mk_reply('0, 1'b0);
          end else begin
            tx_q <= mk_reply(rd_data, err_q);
          end
        end else begin
          wr_pend_q <= 1'b1;
          wr_addr_q <= cmd_addr;
          tx_q      <= mk_reply(rd_data, err_q);
        end
      end
    end
  end

  assign tx_word     = tx_q;
  assign sw_reset    = sw_q;
  assign por_disable = (por_q == POR_KEY);

  AST_PAR_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    frame_done && (^rx_word) |=> err_q && stat_q[ST_PAR]); // R1
  AST_CLK_SETS_STAT: assert property (@(posedge clk) disable iff (rst)
    frame_done && !count_ok |=> err_q && stat_q[ST_CLK]); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q && !frame_done |=> err_q); // R7
  AST_WR_ONE_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_pend_q && frame_done |=> !wr_pend_q); // R4
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    frame_done && frame_bad |=> $stable(agc_q) && $stable(por_q)); // R12
  AST_NOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    frame_done && !wr_pend_q && (rx_word == '0) && count_ok |=> !wr_pend_q); // R13
endmodule

// File: rtl/sens_spi_slave.sv
module sens_spi_slave
  import sens_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  input  logic [DATA_W-1:0] meas_in,
  output logic              miso,
  output logic              miso_oe,
  output logic              por_disable,
  output logic              sw_reset
);
  logic               sck_rise;
  logic               sck_fall;
  logic               sel_start;
  logic               sel_end;
  logic               sel_active;
  logic               mosi_s;
  logic [FRAME_W-1:0] rx_word;
  logic [FRAME_W-1:0] tx_word;
  logic               frame_done;
  logic               count_ok;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .sck_i      (sck),
    .ssn_i      (ss_n),
    .mosi_i     (mosi),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .sel_active (sel_active),
    .mosi_s     (mosi_s)
  );

  spi_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .sel_active (sel_active),
    .mosi_s     (mosi_s),
    .tx_word    (tx_word),
    .rx_word    (rx_word),
    .frame_done (frame_done),
    .count_ok   (count_ok),
    .miso       (miso),
    .miso_oe    (miso_oe)
  );

  sens_reg_bank u_bank (
    .clk         (clk),
    .rst         (rst),
    .frame_done  (frame_done),
    .rx_word     (rx_word),
    .count_ok    (count_ok),
    .meas_in     (meas_in),
    .tx_word     (tx_word),
    .por_disable (por_disable),
    .sw_reset    (sw_reset)
  );
endmodule

// File: tb/sens_spi_slave_tb.sv
module sens_spi_slave_tb;
  localparam logic [13:0] MEAS = 14'h2A5C;

  function automatic logic [15:0] rd(input logic [13:0] a);
    return {1'b1, a, ^{1'b1, a}};
  endfunction
  function automatic logic [15:0] wr(input logic [13:0] a);
    return {1'b0, a, ^a};
  endfunction
  function automatic logic [15:0] dt(input logic [13:0] d);
    return {d, 1'b0, ^d};
  endfunction
  function automatic logic [15:0] rp(input logic [13:0] d, input logic ef);
    return {d, ef, ^{d, ef}};
  endfunction

  localparam int NV = 18;
  // R2 R3 R4 R6 R7 R8 R10 R13 R14 sequence
  localparam logic [15:0] V_TX [NV] = '{
    rd(14'h3FF8), rd(14'h3F20), wr(14'h3FF8), dt(14'h0015), rd(14'h3FFF),
    wr(14'h3F22), dt(14'h005A), 16'h0000, rd(14'h335A), rd(14'h3FF8) ^ 16'h0001,
    rd(14'h335A), rd(14'h3380), 16'h0000, rd(14'h1234), rd(14'h335A),
    rd(14'h3380), rd(14'h3FF8), 16'h0000};
  localparam logic [15:0] V_RX [NV] = '{
    16'h0000, rp(14'h0020, 1'b0), rp(14'h0200, 1'b0), rp(14'h0020, 1'b0),
    rp(14'h0015, 1'b0), rp(MEAS, 1'b0), 16'h0000, rp(14'h005A, 1'b0),
    16'h0000, 16'h0000, rp(14'h0000, 1'b1), rp(14'h0001, 1'b1), 16'h0000,
    16'h0000, rp(14'h0000, 1'b1), rp(14'h0004, 1'b1), 16'h0000,
    rp(14'h0015, 1'b0)};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic ss_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe, por_disable, sw_reset;

  int checks = 0;
  int fails = 0;
  int oe_bad = 0;
  int sw_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sens_spi_slave u_dut (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .meas_in(MEAS), .miso(miso), .miso_oe(miso_oe),
    .por_disable(por_disable), .sw_reset(sw_reset)
  );

  always @(posedge clk) if (!rst && sw_reset) sw_cnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nclk, output logic [15:0] r);
    r = '0;
    @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sck  = 1'b1;
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (i < 16) r[15-i] = miso;
      if (!miso_oe) oe_bad++;
      sck = 1'b0;
      repeat (8) @(negedge clk);
    end
    ss_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    logic [15:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 reset oe", {15'b0, miso_oe}, 16'h0000);
    chk("R10 reset por_disable", {15'b0, por_disable}, 16'h0000);
    chk("R9 reset sw_reset", {15'b0, sw_reset}, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      xfer(V_TX[k], 16, r);
      chk($sformatf("R2/R3 vector %0d", k), r, V_RX[k]);
    end
    chk("R10 por_disable after key", {15'b0, por_disable}, 16'h0001);
    chk("R11 oe during frames", 16'(oe_bad), 16'h0000);
    chk("R11 oe idle", {15'b0, miso_oe}, 16'h0000);

    // R5 short frame
    xfer(16'h0000, 15, r);
    xfer(rd(14'h335A), 16, r);
    chk("R5 short frame ef", r, rp(14'h0000, 1'b1));
    xfer(rd(14'h3380), 16, r);
    chk("R8 clock status bit", r, rp(14'h0002, 1'b1));
    xfer(16'h0000, 16, r);
    chk("R7 cleared", r, 16'h0000);

    // R5 long frame
    xfer(rd(14'h3FF8), 17, r);
    xfer(16'h0000, 16, r);
    chk("R5 long frame ef", r, rp(14'h0000, 1'b1));
    xfer(rd(14'h3380), 16, r);
    xfer(16'h0000, 16, r);
    chk("R7 clear after long", r, 16'h0000);

    // R12 bad data frame
    xfer(wr(14'h3FF8), 16, r);
    xfer(dt(14'h003F) ^ 16'h0001, 16, r);
    chk("R4 old content on write", r, rp(14'h0015, 1'b0));
    xfer(rd(14'h3FF8), 16, r);
    chk("R12 bad data ef", r, rp(14'h0000, 1'b1));
    xfer(rd(14'h3380), 16, r);
    chk("R12 gain unchanged", r, rp(14'h0015, 1'b1));
    xfer(16'h0000, 16, r);
    chk("R13 nop after clear", r, 16'h0000);

    // R9 soft reset keeping error
    xfer(16'h0001, 16, r);
    xfer(wr(14'h3C00), 16, r);
    chk("R1 parity ef", r, rp(14'h0000, 1'b1));
    xfer(dt(14'h0000), 16, r);
    chk("R9 swrst cmd reply", r, rp(14'h0000, 1'b1));
    xfer(rd(14'h3FF8), 16, r);
    chk("R9 swrst data reply keeps ef", r, rp(14'h0000, 1'b1));
    chk("R9 pulse count", 16'(sw_cnt), 16'h0001);
    xfer(rd(14'h3F22), 16, r);
    chk("R9 gain restored", r, rp(14'h0020, 1'b1));
    xfer(16'h0000, 16, r);
    chk("R9 por reg restored", r, rp(14'h0000, 1'b1));
    chk("R10 por_disable cleared", {15'b0, por_disable}, 16'h0000);

    // R9 soft reset clearing error
    xfer(wr(14'h3C00), 16, r);
    xfer(dt(14'h0001), 16, r);
    xfer(16'h0000, 16, r);
    chk("R9 spi regs reset", r, 16'h0000);
    xfer(rd(14'h335A), 16, r);
    xfer(16'h0000, 16, r);
    chk("R8 status cleared by swrst", r, 16'h0000);
    chk("R9 second pulse", 16'(sw_cnt), 16'h0002);

    // R6 write to read-only address
    xfer(wr(14'h3FFF), 16, r);
    xfer(16'h0000, 16, r);
    chk("R6 write read-only ef", r, rp(14'h0000, 1'b1));
    xfer(rd(14'h335A), 16, r);
    xfer(rd(14'h3380), 16, r);
    chk("R6 address status bit", r, rp(14'h0004, 1'b1));
    xfer(16'h0000, 16, r);
    chk("R7 clear reply", r, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule